// File: doc/BRIEF.md
# Clear-on-read interrupt status unit

The unit gathers eight event sources from an audio serial interface (transmitter, receiver and rate converter) and holds each one in a sticky status bit. An 8-bit enable mask sits next to the status byte. Both are reached through a simple host register port in which one strobe reads and one strobe writes.

A single active-high interrupt line is raised when any enabled status bit that is allowed to interrupt is set. The receive channel-status A/B mismatch bit is reported in the status byte but never drives the interrupt line. Its mask position is reserved.

The host takes the interrupt, reads the status byte, and that read clears the byte. Two events are qualified inside the unit:

- The transmit channel-status collision counts only when a buffer write and a buffer copy happen together.
- The receive channel-status event depends on a mode input.

Top module: `irq_status_unit`

## Requirements
- R1: After reset the status byte reads 0x00, the mask reads 0x00 and `irq_o` is 0.
- R2: Each status bit is set by its event and stays set until the status byte is read. The bit positions are: 7 converter error, 6 transmit channel-status write collision, 5 transmit user buffer empty, 4 transmit channel-status block sent, 3 receive channel-status A/B mismatch, 2 receive user block ready, 1 receive channel-status block, 0 receive error.
- R3: A read strobe at address 0x1C returns the current status byte on `reg_rdata_o` in the same cycle. The status byte is 0x00 from the next cycle on, unless an event arrives.
- R4: An event in the same cycle as a status read wins. Its bit is set after the clear.
- R5: A write strobe at address 0x1D loads the mask, and a read of 0x1D returns it. Mask bit 3 always reads 0. A mask bit of 1 enables its status bit and 0 blocks it.
- R6: `irq_o` is the OR of (status AND mask) over bits 7:4 and 2:0. It is registered, so it follows the status and mask one cycle later.
- R7: Status bit 3 never raises `irq_o`, whatever value was written to the mask.
- R8: Bit 6 sets only when `tx_cs_wr_i` and `tx_cs_copy_i` are both high in the same cycle.
- R9: Bit 1 sets on `rx_cs_block_i` when `rx_cs_mode_i` is 0. When `rx_cs_mode_i` is 1, it sets only when `rx_cs_block_i` and `rx_cs_chg_i` are both high.
- R10: Writes to 0x1C leave the status byte unchanged. Reads of 0x1D or of any other address have no side effect. Addresses other than 0x1C and 0x1D read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 7 | Register address |
| reg_wr_i | input | 1 | Write strobe |
| reg_rd_i | input | 1 | Read strobe |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data (combinational) |
| src_err_i | input | 1 | Converter error summary event |
| tx_cs_wr_i | input | 1 | Host write to the transmit channel-status buffer |
| tx_cs_copy_i | input | 1 | Transmit channel-status copy in progress |
| tx_ub_empty_i | input | 1 | Transmit user buffer empty event |
| tx_csb_sent_i | input | 1 | Transmit channel-status block sent event |
| rx_cs_diff_i | input | 1 | Receive channel-status A/B mismatch event |
| rx_ub_ready_i | input | 1 | Receive user block ready event |
| rx_cs_block_i | input | 1 | New receive channel-status block |
| rx_cs_chg_i | input | 1 | Receive channel-status content changed |
| rx_cs_mode_i | input | 1 | 0: flag every block, 1: flag changes only |
| rx_err_i | input | 1 | Receive error summary event |
| irq_o | output | 1 | Combined interrupt, registered, active high |

## Verification
The hardest case to reach from the ports is an event that lands in the exact cycle a status read clears the byte. If the clear and the set are ordered wrongly, the event is silently lost.

The bench drives the event input and the read strobe on the same falling edge. It then reads the byte again to show that the bit survived.

The qualified bits also need input combinations that must *not* set them: a write without a copy, a copy alone, and change-only mode without a change. The reserved bit 3 is tried with the mask fully set, to show it cannot raise the interrupt.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NUM_SRC = 8;
  typedef logic [NUM_SRC-1:0] irq_vec_t;

  localparam int BIT_RX_ERR    = 0;
  localparam int BIT_RX_CS     = 1;
  localparam int BIT_RX_UB     = 2;
  localparam int BIT_RX_DIFF   = 3;
  localparam int BIT_TX_CSB    = 4;
  localparam int BIT_TX_UB     = 5;
  localparam int BIT_TX_COLL   = 6;
  localparam int BIT_SRC_ERR   = 7;

  // bits allowed to drive the interrupt line; also the writable mask bits
  localparam irq_vec_t IRQ_CAPABLE = ~(irq_vec_t'(1) << BIT_RX_DIFF);
endpackage

// File: rtl/irq_event_qual.sv
module irq_event_qual
  import irq_pkg::*;
(
  input  logic     src_err_i,
  input  logic     tx_cs_wr_i,
  input  logic     tx_cs_copy_i,
  input  logic     tx_ub_empty_i,
  input  logic     tx_csb_sent_i,
  input  logic     rx_cs_diff_i,
  input  logic     rx_ub_ready_i,
  input  logic     rx_cs_block_i,
  input  logic     rx_cs_chg_i,
  input  logic     rx_cs_mode_i,
  input  logic     rx_err_i,
  output irq_vec_t set_o
);
  always_comb begin
    set_o              = '0;
    set_o[BIT_SRC_ERR] = src_err_i;
    set_o[BIT_TX_COLL] = tx_cs_wr_i & tx_cs_copy_i;
    set_o[BIT_TX_UB]   = tx_ub_empty_i;
    set_o[BIT_TX_CSB]  = tx_csb_sent_i;
    set_o[BIT_RX_DIFF] = rx_cs_diff_i;
    set_o[BIT_RX_UB]   = rx_ub_ready_i;
    // mode 1: only changed content counts
    set_o[BIT_RX_CS]   = rx_cs_block_i & (~rx_cs_mode_i | rx_cs_chg_i);
    set_o[BIT_RX_ERR]  = rx_err_i;
  end
endmodule

// File: rtl/irq_sticky_bank.sv
module irq_sticky_bank #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] set_i,
  input  logic             clr_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       bit_q <= 1'b0;
      else if (set_i[b]) bit_q <= 1'b1;  // set beats clear
      else if (clr_i)    bit_q <= 1'b0;
    end
    assign q_o[b] = bit_q;
  end
endmodule

// File: rtl/irq_reg_port.sv
module irq_reg_port #(
  parameter int              ADDR_W      = 7,
  parameter int              DATA_W      = 8,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 7'h1C,
  parameter logic [ADDR_W-1:0] MASK_ADDR   = 7'h1D
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] status_i,
  input  logic [DATA_W-1:0] mask_i,
  output logic              stat_clr_o,
  output logic              mask_we_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic hit_stat, hit_mask;
  assign hit_stat   = (addr_i == STATUS_ADDR);
  assign hit_mask   = (addr_i == MASK_ADDR);
  assign stat_clr_o = rd_i & hit_stat;
  assign mask_we_o  = wr_i & hit_mask;

  always_comb begin
    rdata_o = '0;
    if (hit_stat)      rdata_o = status_i;
    else if (hit_mask) rdata_o = mask_i;
  end
endmodule

// File: rtl/irq_out_gen.sv
module irq_out_gen #(
  parameter int                 WIDTH   = 8,
  parameter logic [WIDTH-1:0]   CAPABLE = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] status_i,
  input  logic [WIDTH-1:0] mask_i,
  output logic             irq_o
);
  logic irq_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(status_i & mask_i & CAPABLE);
  end
  assign irq_o = irq_q;
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
  import irq_pkg::*;
#(
  parameter int                ADDR_W      = 7,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 7'h1C,
  parameter logic [ADDR_W-1:0] MASK_ADDR   = 7'h1D
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  input  logic              src_err_i,
  input  logic              tx_cs_wr_i,
  input  logic              tx_cs_copy_i,
  input  logic              tx_ub_empty_i,
  input  logic              tx_csb_sent_i,
  input  logic              rx_cs_diff_i,
  input  logic              rx_ub_ready_i,
  input  logic              rx_cs_block_i,
  input  logic              rx_cs_chg_i,
  input  logic              rx_cs_mode_i,
  input  logic              rx_err_i,
  output logic              irq_o
);
  irq_vec_t set_vec, status_q, mask_q;
  logic     stat_clr, mask_we;

  irq_event_qual u_qual (
    .src_err_i     (src_err_i),
    .tx_cs_wr_i    (tx_cs_wr_i),
    .tx_cs_copy_i  (tx_cs_copy_i),
    .tx_ub_empty_i (tx_ub_empty_i),
    .tx_csb_sent_i (tx_csb_sent_i),
    .rx_cs_diff_i  (rx_cs_diff_i),
    .rx_ub_ready_i (rx_ub_ready_i),
    .rx_cs_block_i (rx_cs_block_i),
    .rx_cs_chg_i   (rx_cs_chg_i),
    .rx_cs_mode_i  (rx_cs_mode_i),
    .rx_err_i      (rx_err_i),
    .set_o         (set_vec)
  );

  irq_sticky_bank #(.WIDTH(NUM_SRC)) u_status (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_vec),
    .clr_i  (stat_clr),
    .q_o    (status_q)
  );

  irq_reg_port #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (NUM_SRC),
    .STATUS_ADDR (STATUS_ADDR),
    .MASK_ADDR   (MASK_ADDR)
  ) u_port (
    .addr_i     (reg_addr_i),
    .wr_i       (reg_wr_i),
    .rd_i       (reg_rd_i),
    .status_i   (status_q),
    .mask_i     (mask_q),
    .stat_clr_o (stat_clr),
    .mask_we_o  (mask_we),
    .rdata_o    (reg_rdata_o)
  );

  // reserved mask positions are not stored
  for (genvar b = 0; b < NUM_SRC; b++) begin : g_mask
    if (IRQ_CAPABLE[b]) begin : g_rw
      logic m_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      m_q <= 1'b0;
        else if (mask_we) m_q <= reg_wdata_i[b];
      end
      assign mask_q[b] = m_q;
    end else begin : g_rsvd
      assign mask_q[b] = 1'b0;
    end
  end

  irq_out_gen #(.WIDTH(NUM_SRC), .CAPABLE(IRQ_CAPABLE)) u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .status_i (status_q),
    .mask_i   (mask_q),
    .irq_o    (irq_o)
  );
endmodule

// File: rtl/irq_status_unit_chk.sv
module irq_status_unit_chk
  import irq_pkg::*;
#(
  parameter int                ADDR_W      = 7,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 7'h1C
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic              reg_rd_i,
  input logic              reg_wr_i,
  input irq_vec_t          set_vec,
  input irq_vec_t          status_q,
  input irq_vec_t          mask_q,
  input logic              irq_o
);
  logic rd_stat;
  assign rd_stat = reg_rd_i && (reg_addr_i == STATUS_ADDR);

  assert_sticky_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_stat |=> ((status_q & $past(status_q)) == $past(status_q)));

  assert_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_stat && set_vec == '0) |=> (status_q == '0));

  assert_event_wins_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_vec != '0) |=> ((status_q & $past(set_vec)) == $past(set_vec)));

  assert_rsvd_mask_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_q[BIT_RX_DIFF] == 1'b0);

  assert_irq_follow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_o == $past(|(status_q & mask_q & IRQ_CAPABLE))));

  assert_diff_no_irq_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((status_q & mask_q & IRQ_CAPABLE) == '0) |=> !irq_o);

  assert_stat_wr_ignored_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && !rd_stat && set_vec == '0) |=> $stable(status_q));
endmodule

bind irq_status_unit irq_status_unit_chk #(
  .ADDR_W      (ADDR_W),
  .STATUS_ADDR (STATUS_ADDR)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_addr_i (reg_addr_i),
  .reg_rd_i   (reg_rd_i),
  .reg_wr_i   (reg_wr_i),
  .set_vec    (set_vec),
  .status_q   (status_q),
  .mask_q     (mask_q),
  .irq_o      (irq_o)
);

// File: tb/irq_status_unit_tb_top.sv
`timescale 1ns/1ps
module irq_status_unit_tb_top;
  localparam logic [6:0] A_STAT = 7'h1C;
  localparam logic [6:0] A_MASK = 7'h1D;
  // ev bits: 0 rx_err,1 rx_cs_block,2 rx_cs_chg,3 rx_cs_mode,4 rx_ub_ready,
  // 5 rx_cs_diff,6 tx_csb_sent,7 tx_ub_empty,8 tx_cs_wr,9 tx_cs_copy,10 src_err
  // vector: {ev[10:0], mask[7:0], exp_status[7:0], exp_irq}
  localparam int NV = 15;
  localparam logic [27:0] VEC [NV] = '{
    {11'h001, 8'hFF, 8'h01, 1'b1},  // R2 R6
    {11'h001, 8'h00, 8'h01, 1'b0},  // R5 blocked
    {11'h020, 8'hFF, 8'h08, 1'b0},  // R7
    {11'h100, 8'hFF, 8'h00, 1'b0},  // R8 write only
    {11'h300, 8'hFF, 8'h40, 1'b1},  // R8
    {11'h002, 8'hFF, 8'h02, 1'b1},  // R9 mode 0
    {11'h00A, 8'hFF, 8'h00, 1'b0},  // R9 mode 1 unchanged
    {11'h00E, 8'hFF, 8'h02, 1'b1},  // R9 mode 1 changed
    {11'h480, 8'h80, 8'hA0, 1'b1},  // R2 R6
    {11'h400, 8'h7F, 8'h80, 1'b0},  // R5
    {11'h050, 8'h10, 8'h14, 1'b1},  // R2
    {11'h040, 8'h04, 8'h10, 1'b0},  // R6
    {11'h020, 8'h08, 8'h08, 1'b0},  // R7
    {11'h200, 8'hFF, 8'h00, 1'b0},  // R8 copy only
    {11'h00C, 8'hFF, 8'h00, 1'b0}   // R9 change without block
  };

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [6:0] reg_addr_i = '0;
  logic reg_wr_i = 1'b0, reg_rd_i = 1'b0;
  logic [7:0] reg_wdata_i = '0, reg_rdata_o;
  logic [10:0] ev = '0;
  logic irq_o;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  irq_status_unit dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .reg_addr_i(reg_addr_i),
    .reg_wr_i(reg_wr_i), .reg_rd_i(reg_rd_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o),
    .src_err_i(ev[10]), .tx_cs_wr_i(ev[8]), .tx_cs_copy_i(ev[9]),
    .tx_ub_empty_i(ev[7]), .tx_csb_sent_i(ev[6]), .rx_cs_diff_i(ev[5]),
    .rx_ub_ready_i(ev[4]), .rx_cs_block_i(ev[1]), .rx_cs_chg_i(ev[2]),
    .rx_cs_mode_i(ev[3]), .rx_err_i(ev[0]), .irq_o(irq_o)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic reg_write(logic [6:0] a, logic [7:0] d);
    @(negedge clk_i);
    reg_addr_i = a; reg_wdata_i = d; reg_wr_i = 1'b1;
    @(negedge clk_i);
    reg_wr_i = 1'b0;
  endtask

  task automatic reg_read(logic [6:0] a, output logic [7:0] d);
    @(negedge clk_i);
    reg_addr_i = a; reg_rd_i = 1'b1;
    #0.5 d = reg_rdata_o;
    @(negedge clk_i);
    reg_rd_i = 1'b0;
  endtask

  task automatic pulse(logic [10:0] e);
    @(negedge clk_i);
    ev = e;
    @(negedge clk_i);
    ev = '0;
  endtask

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk_i);
    check("R1 irq", {7'b0, irq_o}, 8'h00);
    rst_ni = 1'b1;
    reg_read(A_STAT, d); check("R1 status", d, 8'h00);
    reg_read(A_MASK, d); check("R1 mask", d, 8'h00);
    check("R1 irq after", {7'b0, irq_o}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [10:0] e;
      logic [7:0] m, s;
      logic q;
      {e, m, s, q} = VEC[i];
      reg_write(A_MASK, m);
      reg_read(A_MASK, d); check("R5 mask readback", d, m & 8'hF7);
      pulse(e);
      @(negedge clk_i);
      check("R6 irq", {7'b0, irq_o}, {7'b0, q});
      reg_read(A_STAT, d); check("R2 status", d, s);
      @(negedge clk_i);
      check("R3 irq drop", {7'b0, irq_o}, 8'h00);
      reg_read(A_STAT, d); check("R3 cleared", d, 8'h00);
    end

    // sticky over many cycles, irq stays
    reg_write(A_MASK, 8'h01);
    pulse(11'h001);
    repeat (6) @(negedge clk_i);
    check("R2 irq held", {7'b0, irq_o}, 8'h01);
    // status write ignored, mask read no effect
    reg_write(A_STAT, 8'h00);
    reg_read(A_MASK, d); check("R10 mask read", d, 8'h01);
    reg_read(7'h1E, d); check("R10 other addr", d, 8'h00);
    check("R10 irq kept", {7'b0, irq_o}, 8'h01);
    reg_read(A_STAT, d); check("R10 status kept", d, 8'h01);
    reg_read(A_STAT, d); check("R3 second read", d, 8'h00);

    // event in same cycle as status read
    pulse(11'h040);
    @(negedge clk_i);
    reg_addr_i = A_STAT; reg_rd_i = 1'b1; ev = 11'h010;
    #0.5 check("R3 read value", reg_rdata_o, 8'h10);
    @(negedge clk_i);
    reg_rd_i = 1'b0; ev = '0;
    reg_read(A_STAT, d); check("R4 event survives", d, 8'h04);

    // mask all ones with only bit 3 set
    reg_write(A_MASK, 8'hFF);
    pulse(11'h020);
    repeat (3) @(negedge clk_i);
    check("R7 no irq", {7'b0, irq_o}, 8'h00);
    reg_read(A_STAT, d); check("R7 bit3 visible", d, 8'h08);

    // reset mid-run
    pulse(11'h7FF);
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    check("R1 irq reset", {7'b0, irq_o}, 8'h00);
    rst_ni = 1'b1;
    reg_read(A_STAT, d); check("R1 status reset", d, 8'h00);
    reg_read(A_MASK, d); check("R1 mask reset", d, 8'h00);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule